// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the 12-bit data memory address for the byte-wide and bit-wide file operations of a small 8-bit microcontroller core. Each cycle it takes the instruction's 8-bit file operand, its bank/access select bit, the current 4-bit bank register and an instruction-class hint. One clock edge later it presents the effective address together with a code that names the addressing mode used.

The block holds three 12-bit pointer registers, which are loaded through a write strobe. Pointer-based indirect accesses read one of these registers directly. A configuration input turns on an extended mode. In that mode, access-page operands below 60h stop being absolute addresses and become an unsigned offset added to pointer 2. The instruction decoder sits upstream. The data memory and the ALU sit downstream.

Top module: `dmem_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the outputs become `eff_addr` = 000h and `addr_mode` = 0 (none), and all three pointer registers are cleared to 000h.
- R2: `instr_cls` = 0 (file operand) with `use_bank` = 1 gives `eff_addr` = {`bank_sel`, `file_op`} and `addr_mode` = 1 (banked), whatever the value of `ext_en`.
- R3: `instr_cls` = 0 with `use_bank` = 0, `ext_en` = 0 and `file_op` ≤ 5Fh gives `eff_addr` = {4'h0, `file_op`} and `addr_mode` = 2 (access).
- R4: `instr_cls` = 0 with `use_bank` = 0 and `file_op` ≥ 60h gives `eff_addr` = {4'hF, `file_op`} and `addr_mode` = 2, with `ext_en` either 0 or 1.
- R5: `instr_cls` = 0 with `use_bank` = 0, `ext_en` = 1 and `file_op` ≤ 5Fh gives `eff_addr` = pointer 2 + `file_op` (the operand taken as unsigned) and `addr_mode` = 3 (indexed).
- R6: The indexed sum wraps modulo 4096. For example, pointer 2 = FF0h with operand 5Fh gives 04Fh.
- R7: `instr_cls` = 1 (indirect) gives `eff_addr` = the pointer named by `file_op[1:0]` and `addr_mode` = 4 (indirect), whatever the value of `ext_en`. An index of 3 gives `addr_mode` = 0 and `eff_addr` = 000h.
- R8: `instr_cls` = 2 (inherent) or 3 (literal) gives `addr_mode` = 0 and `eff_addr` = 000h, whatever the value of `ext_en`.
- R9: A rising edge with `ptr_we` = 1 loads `ptr_wdata` into the pointer named by `ptr_idx`. An access in the same cycle still sees the old value. `ptr_idx` = 3 changes no pointer.
- R10: The outputs are registered. They reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_cls | input | 2 | Class: 0 file operand, 1 indirect, 2 inherent, 3 literal |
| file_op | input | 8 | File operand byte from the instruction |
| use_bank | input | 1 | 1 selects the banked form, 0 the access page |
| bank_sel | input | 4 | Current bank register |
| ext_en | input | 1 | Extended-mode configuration enable |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_idx | input | 2 | Pointer to write (0..2) |
| ptr_wdata | input | 12 | Value to write into the pointer |
| eff_addr | output | 12 | Registered effective data address |
| addr_mode | output | 3 | Registered mode code: 0 none, 1 banked, 2 access, 3 indexed, 4 indirect |

## Verification
The bench pushes hard on the 5Fh/60h operand boundary with extended mode on. A design with an off-by-one threshold would send operand 60h to a pointer-relative address instead of F60h, or operand 5Fh to 05Fh instead of pointer 2 + 5Fh. It also loads pointer 2 close to FFFh, so an adder that carries into a thirteenth bit or saturates shows up as a wrong low address.

Banked operands are run with extended mode set, which catches a design that lets the extended mode override the bank bit. Indirect reads are made through pointers 0 and 1 with extended mode set, which catches a design that lets the mode leak into indirect addressing. A write to index 3 is followed by read-back of all three pointers, which catches a stray decode that corrupts a real pointer. A write and a read in the same cycle check that the old pointer value is used.

// File: rtl/dmag_pkg.sv
// Shared encodings for the data memory address generator.
// Assumes: mode and class codes are fixed and are seen by the bench and by downstream logic.
package dmag_pkg;
    typedef enum logic [2:0] {
        AM_NONE     = 3'd0,
        AM_BANKED   = 3'd1,
        AM_ACCESS   = 3'd2,
        AM_INDEXED  = 3'd3,
        AM_INDIRECT = 3'd4
    } addr_mode_e;

    typedef enum logic [1:0] {
        IC_FILE     = 2'd0,
        IC_INDIRECT = 2'd1,
        IC_INHERENT = 2'd2,
        IC_LITERAL  = 2'd3
    } instr_cls_e;
endpackage

// File: rtl/dmag_ptr_file.sv
// Pointer register file: NUM_PTR pointers of ADDR_W bits, written one at a time.
// Assumes: an index at or above NUM_PTR is a no-op; reads see the value held before the edge.
module dmag_ptr_file #(
    parameter int ADDR_W  = 12,
    parameter int NUM_PTR = 3,
    parameter int IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                idx,
    input  logic [ADDR_W-1:0]               wdata,
    output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_q
);
    localparam int IDX_SPAN = 1 << IDX_W;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        // Load pointer i when the strobe names it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[i] <= '0;
            else if (we && idx == IDX_W'(i))
                ptr_q[i] <= wdata;
        end

        // R9: a strobe naming this pointer loads the write data
        a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(i)) |=> ptr_q[i] == $past(wdata));
    end

    if (NUM_PTR < IDX_SPAN) begin : g_bad_idx
        // R9: a write to an unused index leaves every pointer unchanged
        a_r9_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
            (we && 32'(idx) >= NUM_PTR) |=> $stable(ptr_q));
    end
endmodule

// File: rtl/dmag_addr_calc.sv
// Combinational address former: picks banked, access, indexed, indirect or no address.
// Assumes: pointer IDX_PTR is the base for the indexed form; offsets up to OFS_LIMIT are indexed.
module dmag_addr_calc
    import dmag_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         OPND_W    = 8,
    parameter int         NUM_PTR   = 3,
    parameter int         IDX_W     = 2,
    parameter int         IDX_PTR   = 2,
    parameter logic [7:0] OFS_LIMIT = 8'h5F
) (
    input  logic [1:0]                      cls,
    input  logic [OPND_W-1:0]               opnd,
    input  logic                            use_bank,
    input  logic [ADDR_W-OPND_W-1:0]        bank,
    input  logic                            ext_en,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0]  ptr_q,
    output logic [ADDR_W-1:0]               addr_d,
    output addr_mode_e                      mode_d
);
    localparam int PAGE_W = ADDR_W - OPND_W;
    localparam logic [PAGE_W-1:0] HI_PAGE = {PAGE_W{1'b1}};
    localparam logic [PAGE_W-1:0] LO_PAGE = '0;

    logic             low_ofs;
    logic [IDX_W-1:0] ind_idx;

    // Classify the operand against the offset limit and pick the indirect index.
    always_comb begin
        low_ofs = (opnd <= OPND_W'(OFS_LIMIT));
        ind_idx = opnd[IDX_W-1:0];
    end

    // Form the address and mode for this instruction class.
    always_comb begin
        addr_d = '0;
        mode_d = AM_NONE;
        unique case (instr_cls_e'(cls))
            IC_FILE: begin
                if (use_bank) begin
                    addr_d = {bank, opnd};
                    mode_d = AM_BANKED;
                end else if (ext_en && low_ofs) begin
                    addr_d = ptr_q[IDX_PTR] + ADDR_W'(opnd);
                    mode_d = AM_INDEXED;
                end else begin
                    addr_d = {(low_ofs ? LO_PAGE : HI_PAGE), opnd};
                    mode_d = AM_ACCESS;
                end
            end
            IC_INDIRECT: begin
                if (32'(ind_idx) < NUM_PTR) begin
                    addr_d = ptr_q[ind_idx];
                    mode_d = AM_INDIRECT;
                end
            end
            default: begin
                addr_d = '0;
                mode_d = AM_NONE;
            end
        endcase
    end
endmodule

// File: rtl/dmag_out_reg.sv
// Output stage: registers the formed address and mode for one-cycle latency.
// Assumes: reset returns the outputs to address zero with no mode.
module dmag_out_reg
    import dmag_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_d,
    input  addr_mode_e        mode_d,
    output logic [ADDR_W-1:0] addr_q,
    output addr_mode_e        mode_q
);
    // Capture the address and mode each cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= AM_NONE;
        end else begin
            addr_q <= addr_d;
            mode_q <= mode_d;
        end
    end

    // R1: reset leaves address zero with no mode
    a_r1_reset_out: assert property (@(posedge clk)
        !rst_n |=> (addr_q == '0 && mode_q == AM_NONE));
endmodule

// File: rtl/dmem_addr_gen.sv
// Top: data memory address generator with banked, access, indexed and indirect forms.
// Assumes: inputs are steady around the rising edge; outputs lag the inputs by one cycle.
module dmem_addr_gen
    import dmag_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int OPND_W  = 8,
    parameter int NUM_PTR = 3,
    parameter int IDX_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 instr_cls,
    input  logic [OPND_W-1:0]          file_op,
    input  logic                       use_bank,
    input  logic [ADDR_W-OPND_W-1:0]   bank_sel,
    input  logic                       ext_en,
    input  logic                       ptr_we,
    input  logic [IDX_W-1:0]           ptr_idx,
    input  logic [ADDR_W-1:0]          ptr_wdata,
    output logic [ADDR_W-1:0]          eff_addr,
    output logic [2:0]                 addr_mode
);
    localparam int IDX_PTR = 2;
    localparam int PAGE_W  = ADDR_W - OPND_W;

    logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0]              addr_d;
    logic [ADDR_W-1:0]              addr_q;
    addr_mode_e                     mode_d;
    addr_mode_e                     mode_q;

    dmag_ptr_file #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .we(ptr_we), .idx(ptr_idx),
        .wdata(ptr_wdata), .ptr_q(ptr_q)
    );

    dmag_addr_calc #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .NUM_PTR(NUM_PTR),
                     .IDX_W(IDX_W), .IDX_PTR(IDX_PTR)) u_calc (
        .cls(instr_cls), .opnd(file_op), .use_bank(use_bank), .bank(bank_sel),
        .ext_en(ext_en), .ptr_q(ptr_q), .addr_d(addr_d), .mode_d(mode_d)
    );

    dmag_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .addr_d(addr_d), .mode_d(mode_d),
        .addr_q(addr_q), .mode_q(mode_q)
    );

    // Drive the ports from the output stage.
    always_comb begin
        eff_addr  = addr_q;
        addr_mode = mode_q;
    end

    // R2: the bank bit wins over the extended mode
    a_r2_banked: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_cls == IC_FILE && use_bank) |=>
        (eff_addr == {$past(bank_sel), $past(file_op)} && addr_mode == AM_BANKED));

    // R4: high access operands stay on the top page in either mode
    a_r4_high_page: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_cls == IC_FILE && !use_bank && file_op >= OPND_W'(8'h60)) |=>
        (eff_addr[ADDR_W-1 -: PAGE_W] == {PAGE_W{1'b1}} && addr_mode == AM_ACCESS));

    // R5, R6: indexed form adds pointer 2 and wraps in the address space
    a_r5_indexed: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_cls == IC_FILE && !use_bank && ext_en && file_op <= OPND_W'(8'h5F)) |=>
        (eff_addr == ADDR_W'($past(ptr_q[IDX_PTR]) + ADDR_W'($past(file_op)))
         && addr_mode == AM_INDEXED));

    // R8: inherent and literal classes carry no address
    a_r8_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_cls == IC_INHERENT || instr_cls == IC_LITERAL) |=>
        (eff_addr == '0 && addr_mode == AM_NONE));
endmodule

// File: tb/dmem_addr_gen_tb.sv
`timescale 1ns/100ps
module dmem_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  instr_cls;
    logic [7:0]  file_op;
    logic        use_bank;
    logic [3:0]  bank_sel;
    logic        ext_en;
    logic        ptr_we;
    logic [1:0]  ptr_idx;
    logic [11:0] ptr_wdata;
    logic [11:0] eff_addr;
    logic [2:0]  addr_mode;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] mptr [3];

    always #2.5 clk = ~clk;

    dmem_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .instr_cls(instr_cls), .file_op(file_op),
        .use_bank(use_bank), .bank_sel(bank_sel), .ext_en(ext_en),
        .ptr_we(ptr_we), .ptr_idx(ptr_idx), .ptr_wdata(ptr_wdata),
        .eff_addr(eff_addr), .addr_mode(addr_mode)
    );

    // Expected address/mode from the requirement text and the model pointers.
    function automatic logic [14:0] expect_out(input logic [1:0] c, input logic [7:0] op,
                                               input logic ub, input logic [3:0] b,
                                               input logic ex);
        logic [11:0] a;
        logic [2:0]  m;
        a = 12'h000; m = 3'd0;
        if (c == 2'd0) begin
            if (ub) begin a = {b, op}; m = 3'd1; end
            else if (ex && op <= 8'h5F) begin a = mptr[2] + {4'h0, op}; m = 3'd3; end
            else if (op <= 8'h5F) begin a = {4'h0, op}; m = 3'd2; end
            else begin a = {4'hF, op}; m = 3'd2; end
        end else if (c == 2'd1) begin
            if (op[1:0] != 2'd3) begin a = mptr[op[1:0]]; m = 3'd4; end
        end
        return {m, a};
    endfunction

    function automatic string tag_of(input logic [1:0] c, input logic [7:0] op,
                                     input logic ub, input logic ex);
        if (c == 2'd1) return "R7";
        if (c != 2'd0) return "R8";
        if (ub) return "R2";
        if (op >= 8'h60) return "R4";
        if (ex) return "R5";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [11:0] ea, input logic [2:0] em);
        n_cmp++;
        if (eff_addr !== ea || addr_mode !== em) begin
            n_bad++;
            $display("FAIL %s: addr=%h mode=%0d expected addr=%h mode=%0d",
                     tag, eff_addr, addr_mode, ea, em);
        end
    endtask

    // One access: drive at negedge, check just after the capturing edge (R10).
    task automatic apply(input logic [1:0] c, input logic [7:0] op, input logic ub,
                         input logic [3:0] b, input logic ex, input logic we,
                         input logic [1:0] wi, input logic [11:0] wd, input string tag);
        logic [14:0] e;
        @(negedge clk);
        instr_cls = c; file_op = op; use_bank = ub; bank_sel = b; ext_en = ex;
        ptr_we = we; ptr_idx = wi; ptr_wdata = wd;
        e = expect_out(c, op, ub, b, ex);
        @(posedge clk);
        #1;
        check(tag, e[11:0], e[14:12]);
        if (we && wi != 2'd3) mptr[wi] = wd;
    endtask

    task automatic wr(input logic [1:0] wi, input logic [11:0] wd);
        apply(2'd2, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, wi, wd, "R9");
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) mptr[i] = 12'h000;
        rst_n = 1'b0; instr_cls = 2'd0; file_op = 8'h00; use_bank = 1'b0;
        bank_sel = 4'h0; ext_en = 1'b0; ptr_we = 1'b0; ptr_idx = 2'd0; ptr_wdata = 12'h000;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 12'h000, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: pointers read back as zero after reset
        for (int i = 0; i < 3; i++) apply(2'd1, 8'(i), 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R1");

        // Directed corners
        apply(2'd0, 8'h5F, 1'b0, 4'h0, 1'b0, 1'b0, 2'd0, 12'h0, "R3");
        apply(2'd0, 8'h60, 1'b0, 4'h0, 1'b0, 1'b0, 2'd0, 12'h0, "R4");
        wr(2'd2, 12'hFF0);
        apply(2'd0, 8'h5F, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R6");
        apply(2'd0, 8'h10, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R6");
        apply(2'd0, 8'h60, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R4");
        apply(2'd0, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R5");
        apply(2'd0, 8'h20, 1'b1, 4'h7, 1'b1, 1'b0, 2'd0, 12'h0, "R2");
        wr(2'd0, 12'h123);
        wr(2'd1, 12'hABC);
        apply(2'd1, 8'h00, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R7");
        apply(2'd1, 8'h01, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R7");
        apply(2'd1, 8'h03, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R7");
        wr(2'd3, 12'h555);
        for (int i = 0; i < 3; i++) apply(2'd1, 8'(i), 1'b0, 4'h0, 1'b0, 1'b0, 2'd0, 12'h0, "R9");
        // R9: a same-cycle write to pointer 2 is not yet visible to the indexed access
        apply(2'd0, 8'h01, 1'b0, 4'h0, 1'b1, 1'b1, 2'd2, 12'h200, "R9");
        apply(2'd0, 8'h01, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R9");
        apply(2'd3, 8'h10, 1'b0, 4'h0, 1'b1, 1'b0, 2'd0, 12'h0, "R8");
        apply(2'd2, 8'h70, 1'b1, 4'h3, 1'b0, 1'b0, 2'd0, 12'h0, "R8");

        // Constrained random mix, operands biased toward the 5Fh/60h edge
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] c;
            logic [7:0] op;
            logic ub, ex, we;
            c  = ($urandom_range(0, 9) < 6) ? 2'd0 : 2'($urandom_range(1, 3));
            op = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'h5C, 8'h63)) : 8'($urandom);
            ub = ($urandom_range(0, 2) == 0);
            ex = 1'($urandom);
            we = ($urandom_range(0, 4) == 0);
            apply(c, op, ub, 4'($urandom), ex, we, 2'($urandom), 12'($urandom),
                  tag_of(c, op, ub, ex));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule